// File: doc/BRIEF.md
# Host-to-Controller Mailbox Engine

This block puts a small byte-wide host window in front of a 16-bit virtual register space that belongs to an embedded controller. The host never addresses a virtual register directly. It moves a pointer into a small mailbox RAM and writes a request packet into that RAM through four data ports. The packet holds the access kind, the entry count, the data byte and the 16-bit virtual address. The host then rings a doorbell. After a fixed, parameterised service time the engine carries out the access on its internal register array. It posts a completion code, raises a completion interrupt bit and, for a read, leaves the fetched byte in the mailbox data slot.

Typical host use follows a fixed sequence. Clear any stale status and interrupt bits by writing back what was read. Point at the mailbox base and write the header. Move the pointer to the payload and write the data and address. Ring the doorbell. Poll the interrupt register until bit 0 is set, then read the status byte and, for reads, the data slot. Paired 8-bit reads of a 16-bit quantity stay coherent: reading the low byte captures the high byte, which is then returned by the next read.

Top module: `hostec_mailbox`

## Requirements
- R1: After reset, every window offset 0..15 reads 0x00. Offsets 9..15 always read 0x00.
- R2: Offsets 2 and 3 hold the pointer low and high bytes and read back what was written. Offsets 4..7 reach mailbox byte (pointer low + offset − 4) only when the pointer high byte is 0x80 and that byte index is below MBOX_DEPTH. Otherwise writes there are ignored and reads return 0x00.
- R3: Writing 0x01 to offset 0 while idle starts a command. Offset 0 then reads 0x01 until completion and 0x00 afterwards. Any other doorbell value starts nothing.
- R4: A command completes exactly EXEC_CYCLES clock edges after the edge that took the doorbell write, with EXEC_CYCLES between 1 and 64.
- R5: A read command is access kind 0x02 in mailbox byte 0 with count 0x01 in byte 1, and the address low/high in bytes 6/7. It places the addressed virtual byte into mailbox byte 4, which is offset 4 when the pointer is 0x8004.
- R6: A write command (kind 0x03, count 0x01) stores mailbox byte 4 into the addressed virtual register.
- R7: The status byte at offset 1 becomes 0x01 on success. It becomes 0x81 for an unknown access kind, 0x82 for a count other than 0x01, and 0x83 for an address at or above VREG_DEPTH, checked in that priority order. A failed command changes neither the virtual registers, the mailbox nor the pairing capture.
- R8: A host write to offset 1 clears exactly the status bits that are 1 in the written byte.
- R9: Bit 0 of offset 8 is set on every completion. A host write there clears the bits written as 1, and a completion in the same cycle wins.
- R10: A successful read of an even address a with a+1 below VREG_DEPTH captures register a+1. If the next successful read is of a+1, it returns the captured byte even when a write changed the register meanwhile. Every successful read consumes or replaces the capture.
- R11: After reset, virtual register a holds (a·SEED_MUL + SEED_ADD) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe for one cycle |
| bus_addr | input | 4 | Window offset |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Byte at bus_addr, combinational |

## Verification
A corrupted pointer or mailbox byte appears at the next read of offsets 4..7, or as a wrong code or wrong virtual register once the doorbell rings. A wrong service counter shows as a completion bit that rises one edge early or late, and the bench samples the edges on both sides of the expected one. A stale or misdirected pairing capture shows up only at the read that follows an even-address read. For that reason the bench models the capture across the whole address sweep and across writes placed between the two reads.

// File: rtl/hem_pkg.sv
package hem_pkg;
   localparam logic [3:0] OFF_DOORBELL = 4'd0;
   localparam logic [3:0] OFF_STATUS   = 4'd1;
   localparam logic [3:0] OFF_PTR_LO   = 4'd2;
   localparam logic [3:0] OFF_PTR_HI   = 4'd3;
   localparam logic [3:0] OFF_IRQ_SRC  = 4'd8;

   localparam logic [7:0] DOORBELL_GO  = 8'h01;
   localparam logic [7:0] ACC_READ     = 8'h02;
   localparam logic [7:0] ACC_WRITE    = 8'h03;
   localparam logic [7:0] ONE_ENTRY    = 8'h01;

   localparam logic [7:0] CODE_OK        = 8'h01;
   localparam logic [7:0] CODE_BAD_KIND  = 8'h81;
   localparam logic [7:0] CODE_BAD_COUNT = 8'h82;
   localparam logic [7:0] CODE_BAD_ADDR  = 8'h83;

   localparam int SLOT_KIND  = 0;
   localparam int SLOT_COUNT = 1;
   localparam int SLOT_DATA  = 4;
   localparam int SLOT_ALO   = 6;
   localparam int SLOT_AHI   = 7;

   typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;

   typedef struct packed {
      logic [7:0]  kind;
      logic [7:0]  count;
      logic [7:0]  data;
      logic [15:0] addr;
   } req_pkt_t;
endpackage

// File: rtl/hem_mbox_ram.sv
module hem_mbox_ram
   import hem_pkg::*;
#(
   parameter int MBOX_DEPTH = 8,
   parameter int IDX_W      = $clog2(MBOX_DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_idx,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   input  logic             eng_we,
   input  logic [7:0]       eng_wdata,
   output req_pkt_t         pkt
);
   generate
      if (MBOX_DEPTH < 8 || MBOX_DEPTH > 256 || (MBOX_DEPTH & (MBOX_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("hem_mbox_ram: MBOX_DEPTH must be a power of two in 8..256");
      end
   endgenerate

   logic [7:0]            mem [MBOX_DEPTH];
   logic [MBOX_DEPTH-1:0] host_sel;

   generate
      for (genvar gi = 0; gi < MBOX_DEPTH; gi++) begin : g_sel
         assign host_sel[gi] = host_we && (host_idx == IDX_W'(gi));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MBOX_DEPTH; i++) mem[i] <= 8'h00;
      end else begin
         for (int i = 0; i < MBOX_DEPTH; i++) begin
            if (eng_we && i == SLOT_DATA) mem[i] <= eng_wdata;
            else if (host_sel[i])        mem[i] <= host_wdata;
         end
      end
   end

   assign host_rdata = mem[host_idx];
   assign pkt.kind   = mem[SLOT_KIND];
   assign pkt.count  = mem[SLOT_COUNT];
   assign pkt.data   = mem[SLOT_DATA];
   assign pkt.addr   = {mem[SLOT_AHI], mem[SLOT_ALO]};
endmodule

// File: rtl/hem_vreg_file.sv
module hem_vreg_file #(
   parameter int VREG_DEPTH = 64,
   parameter int SEED_MUL   = 37,
   parameter int SEED_ADD   = 11,
   parameter int VA_W       = $clog2(VREG_DEPTH)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [VA_W-1:0] idx,
   input  logic [7:0]      wdata,
   output logic [7:0]      rdata,
   output logic [7:0]      rdata_pair
);
   generate
      if (VREG_DEPTH < 2 || VREG_DEPTH > 4096) begin : g_bad_depth
         $error("hem_vreg_file: VREG_DEPTH must be in 2..4096");
      end
   endgenerate

   logic [7:0]      mem [VREG_DEPTH];
   logic [VA_W-1:0] idx_pair;

   assign idx_pair = idx + VA_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < VREG_DEPTH; i++) mem[i] <= 8'(i * SEED_MUL + SEED_ADD);
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata      = mem[idx];
   assign rdata_pair = mem[idx_pair];
endmodule

// File: rtl/hem_engine.sv
module hem_engine
   import hem_pkg::*;
#(
   parameter int EXEC_CYCLES = 8,
   parameter int VREG_DEPTH  = 64,
   parameter int SEED_MUL    = 37,
   parameter int SEED_ADD    = 11,
   parameter bit LATCH_EN    = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  req_pkt_t   pkt,
   output logic       busy,
   output logic       done,
   output logic [7:0] done_code,
   output logic       mbox_we,
   output logic [7:0] mbox_wdata
);
   localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
   localparam int VA_W  = $clog2(VREG_DEPTH);

   generate
      if (EXEC_CYCLES < 1 || EXEC_CYCLES > 64) begin : g_bad_lat
         $error("hem_engine: EXEC_CYCLES must be in 1..64");
      end
   endgenerate

   eng_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic            kind_ok, count_ok, addr_ok, pair_ok, cmd_ok, is_rd, is_wr;
   logic [7:0]      vr_rdata, vr_pair, rd_val;
   logic [VA_W-1:0] vidx;

   assign busy = (state_q == ENG_WAIT);
   assign done = busy && (cnt_q == CNT_W'(EXEC_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ENG_IDLE: if (start) begin
               state_q <= ENG_WAIT;
               cnt_q   <= CNT_W'(1);
            end
            ENG_WAIT: if (done) begin
               state_q <= ENG_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q   <= cnt_q + CNT_W'(1);
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   // Request decode and completion code, kind first, then count, then address
   assign is_rd    = (pkt.kind == ACC_READ);
   assign is_wr    = (pkt.kind == ACC_WRITE);
   assign kind_ok  = is_rd || is_wr;
   assign count_ok = (pkt.count == ONE_ENTRY);
   assign addr_ok  = ({1'b0, pkt.addr} < 17'(VREG_DEPTH));
   assign pair_ok  = ({1'b0, pkt.addr} + 17'd1 < 17'(VREG_DEPTH));
   assign cmd_ok   = kind_ok && count_ok && addr_ok;
   assign vidx     = pkt.addr[VA_W-1:0];

   always_comb begin
      if (!kind_ok)       done_code = CODE_BAD_KIND;
      else if (!count_ok) done_code = CODE_BAD_COUNT;
      else if (!addr_ok)  done_code = CODE_BAD_ADDR;
      else                done_code = CODE_OK;
   end

   hem_vreg_file #(
      .VREG_DEPTH (VREG_DEPTH),
      .SEED_MUL   (SEED_MUL),
      .SEED_ADD   (SEED_ADD)
   ) u_vreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (done && cmd_ok && is_wr),
      .idx        (vidx),
      .wdata      (pkt.data),
      .rdata      (vr_rdata),
      .rdata_pair (vr_pair)
   );

   generate
      if (LATCH_EN) begin : g_pair_latch
         logic        cap_v;
         logic [15:0] cap_a;
         logic [7:0]  cap_d;
         logic        cap_hit;

         assign cap_hit = cap_v && (pkt.addr == cap_a);
         assign rd_val  = cap_hit ? cap_d : vr_rdata;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_v <= 1'b0;
               cap_a <= '0;
               cap_d <= '0;
            end else if (done && cmd_ok && is_rd) begin
               if (!cap_hit && !pkt.addr[0] && pair_ok) begin
                  cap_v <= 1'b1;
                  cap_a <= pkt.addr + 16'd1;
                  cap_d <= vr_pair;
               end else begin
                  cap_v <= 1'b0;
               end
            end
         end
      end else begin : g_no_latch
         logic unused_pair;
         assign unused_pair = ^{vr_pair, pair_ok};
         assign rd_val      = vr_rdata;
      end
   endgenerate

   assign mbox_we    = done && cmd_ok && is_rd;
   assign mbox_wdata = rd_val;
endmodule

// File: rtl/hem_host_if.sv
module hem_host_if
   import hem_pkg::*;
#(
   parameter int         MBOX_DEPTH = 8,
   parameter logic [7:0] REGION_SEL = 8'h80,
   parameter int         IDX_W      = $clog2(MBOX_DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [3:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             ram_we,
   output logic [IDX_W-1:0] ram_idx,
   input  logic [7:0]       ram_rdata,
   input  logic             eng_busy,
   input  logic             eng_done,
   input  logic [7:0]       eng_code,
   output logic             start,
   output logic             db_q,
   output logic [7:0]       status_q,
   output logic [7:0]       int_q,
   output logic [7:0]       ptr_lo,
   output logic [7:0]       ptr_hi
);
   logic       in_win, win_hit;
   logic [8:0] win_sum;

   assign in_win  = (bus_addr[3:2] == 2'b01);
   assign win_sum = {1'b0, ptr_lo} + {7'b0, bus_addr[1:0]};
   assign win_hit = in_win && (ptr_hi == REGION_SEL) && (win_sum < 9'(MBOX_DEPTH));
   assign ram_idx = win_sum[IDX_W-1:0];
   assign ram_we  = bus_wr && win_hit;

   assign start = bus_wr && (bus_addr == OFF_DOORBELL) && (bus_wdata == DOORBELL_GO) && !eng_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_lo   <= '0;
         ptr_hi   <= '0;
         db_q     <= 1'b0;
         status_q <= '0;
         int_q    <= '0;
      end else begin
         if (bus_wr && bus_addr == OFF_PTR_LO) ptr_lo <= bus_wdata;
         if (bus_wr && bus_addr == OFF_PTR_HI) ptr_hi <= bus_wdata;

         if (eng_done)   db_q <= 1'b0;
         else if (start) db_q <= 1'b1;

         if (eng_done)
            status_q <= eng_code;
         else if (bus_wr && bus_addr == OFF_STATUS)
            status_q <= status_q & ~bus_wdata;

         if (bus_wr && bus_addr == OFF_IRQ_SRC) begin
            int_q <= {int_q[7:1] & ~bus_wdata[7:1], (int_q[0] & ~bus_wdata[0]) | eng_done};
         end else if (eng_done) begin
            int_q[0] <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      unique case (bus_addr)
         OFF_DOORBELL:               bus_rdata = {7'b0, db_q};
         OFF_STATUS:                 bus_rdata = status_q;
         OFF_PTR_LO:                 bus_rdata = ptr_lo;
         OFF_PTR_HI:                 bus_rdata = ptr_hi;
         4'd4, 4'd5, 4'd6, 4'd7:     bus_rdata = win_hit ? ram_rdata : 8'h00;
         OFF_IRQ_SRC:                bus_rdata = int_q;
         default:                    bus_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/hostec_mailbox.sv
module hostec_mailbox
   import hem_pkg::*;
#(
   parameter int         EXEC_CYCLES = 8,
   parameter int         VREG_DEPTH  = 64,
   parameter int         MBOX_DEPTH  = 8,
   parameter logic [7:0] REGION_SEL  = 8'h80,
   parameter int         SEED_MUL    = 37,
   parameter int         SEED_ADD    = 11,
   parameter bit         LATCH_EN    = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [3:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata
);
   localparam int IDX_W = $clog2(MBOX_DEPTH);

   generate
      if (EXEC_CYCLES < 1 || EXEC_CYCLES > 64) begin : g_bad_lat
         $error("hostec_mailbox: EXEC_CYCLES must be in 1..64");
      end
      if (VREG_DEPTH > 65536) begin : g_bad_vreg
         $error("hostec_mailbox: VREG_DEPTH exceeds the 16-bit space");
      end
   endgenerate

   logic             ram_we, start, eng_busy, eng_done, mbox_we, db_q;
   logic [IDX_W-1:0] ram_idx;
   logic [7:0]       ram_rdata, eng_code, mbox_wdata, status_q, int_q, ptr_lo, ptr_hi;
   req_pkt_t         pkt;

   hem_host_if #(
      .MBOX_DEPTH (MBOX_DEPTH),
      .REGION_SEL (REGION_SEL)
   ) u_host_if (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ram_we    (ram_we),
      .ram_idx   (ram_idx),
      .ram_rdata (ram_rdata),
      .eng_busy  (eng_busy),
      .eng_done  (eng_done),
      .eng_code  (eng_code),
      .start     (start),
      .db_q      (db_q),
      .status_q  (status_q),
      .int_q     (int_q),
      .ptr_lo    (ptr_lo),
      .ptr_hi    (ptr_hi)
   );

   hem_mbox_ram #(
      .MBOX_DEPTH (MBOX_DEPTH)
   ) u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (ram_we),
      .host_idx   (ram_idx),
      .host_wdata (bus_wdata),
      .host_rdata (ram_rdata),
      .eng_we     (mbox_we),
      .eng_wdata  (mbox_wdata),
      .pkt        (pkt)
   );

   hem_engine #(
      .EXEC_CYCLES (EXEC_CYCLES),
      .VREG_DEPTH  (VREG_DEPTH),
      .SEED_MUL    (SEED_MUL),
      .SEED_ADD    (SEED_ADD),
      .LATCH_EN    (LATCH_EN)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .pkt        (pkt),
      .busy       (eng_busy),
      .done       (eng_done),
      .done_code  (eng_code),
      .mbox_we    (mbox_we),
      .mbox_wdata (mbox_wdata)
   );
endmodule

// File: rtl/hem_checker.sv
module hem_checker
   import hem_pkg::*;
#(
   parameter int EXEC_CYCLES = 8
)(
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic [3:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       eng_busy,
   input logic       eng_done,
   input logic       db_q,
   input logic [7:0] status_q,
   input logic [7:0] int_q,
   input logic [7:0] ptr_lo
);
   logic [6:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_cnt <= '0;
      else if (eng_busy) lat_cnt <= lat_cnt + 7'd1;
      else               lat_cnt <= '0;
   end

   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_PTR_LO) |=> (ptr_lo == $past(bus_wdata))); // R2

   AST_DB_START: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_DOORBELL && bus_wdata == DOORBELL_GO && !eng_busy) |=> (eng_busy && db_q)); // R3

   AST_DB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !db_q); // R3

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> (lat_cnt < 7'(EXEC_CYCLES))); // R4

   AST_EXACT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |-> (lat_cnt == 7'(EXEC_CYCLES - 1))); // R4

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (status_q == CODE_OK || status_q == CODE_BAD_KIND ||
                    status_q == CODE_BAD_COUNT || status_q == CODE_BAD_ADDR)); // R7

   AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_STATUS && !eng_done) |=> (status_q == ($past(status_q) & ~$past(bus_wdata)))); // R8

   AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> int_q[0]); // R9

   AST_INT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_IRQ_SRC && bus_wdata[0] && !eng_done) |=> !int_q[0]); // R9
endmodule

bind hostec_mailbox hem_checker #(
   .EXEC_CYCLES (EXEC_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .eng_busy  (eng_busy),
   .eng_done  (eng_done),
   .db_q      (db_q),
   .status_q  (status_q),
   .int_q     (int_q),
   .ptr_lo    (ptr_lo)
);

// File: tb/hostec_mailbox_bench.sv
`timescale 1ns/1ps
module hostec_mailbox_bench;
   localparam int EXEC = 4;
   localparam int VD   = 64;
   localparam int SMUL = 37;
   localparam int SADD = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;

   int checks = 0;
   int fails  = 0;

   logic [7:0]  mv [VD];
   bit          lv;
   int          la;
   logic [7:0]  ld;

   always #2.5 clk = ~clk;

   hostec_mailbox #(
      .EXEC_CYCLES (EXEC),
      .VREG_DEPTH  (VD),
      .MBOX_DEPTH  (8),
      .REGION_SEL  (8'h80),
      .SEED_MUL    (SMUL),
      .SEED_ADD    (SADD),
      .LATCH_EN    (1'b1)
   ) u_hostec_mailbox (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] off, input logic [7:0] val);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = off; bus_wdata = val;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [3:0] off, output logic [7:0] val);
      bus_addr = off;
      #1;
      val = bus_rdata;
   endtask

   task automatic rd(input logic [3:0] off, output logic [7:0] val);
      @(negedge clk);
      peek(off, val);
   endtask

   // Issue one command; checks doorbell and exact completion edge (R3, R4, R9)
   task automatic run_cmd(input logic [7:0] kind, input logic [7:0] cnt, input logic [15:0] addr,
                          input logic [7:0] data, output logic [7:0] code, output logic [7:0] rbyte);
      logic [7:0] v;
      wr(4'd2, 8'h00); wr(4'd3, 8'h80);
      wr(4'd4, kind);  wr(4'd5, cnt);
      wr(4'd2, 8'h04);
      wr(4'd4, data);  wr(4'd6, addr[7:0]); wr(4'd7, addr[15:8]);
      rd(4'd1, v); wr(4'd1, v);
      wr(4'd8, 8'hFF);
      wr(4'd0, 8'h01);
      peek(4'd0, v); chk(v, 8'h01, "R3 doorbell reads busy");
      repeat (EXEC - 1) @(negedge clk);
      peek(4'd8, v); chk(v, 8'h00, "R4 no completion one edge early");
      @(negedge clk);
      peek(4'd8, v); chk(v, 8'h01, "R9 R4 completion bit at exact edge");
      peek(4'd0, v); chk(v, 8'h00, "R3 doorbell idle after completion");
      peek(4'd1, code);
      peek(4'd4, rbyte);
   endtask

   task automatic do_read(input int a);
      logic [7:0] code, rb, e;
      if (lv && a == la) begin
         e = ld; lv = 0;
      end else begin
         e = mv[a];
         if (a % 2 == 0 && a + 1 < VD) begin lv = 1; la = a + 1; ld = mv[a+1]; end
         else lv = 0;
      end
      run_cmd(8'h02, 8'h01, 16'(a), 8'h00, code, rb);
      chk(code, 8'h01, "R7 read success code");
      chk(rb, e, "R5 R10 R11 read data");
   endtask

   task automatic do_write(input int a, input logic [7:0] val);
      logic [7:0] code, rb;
      run_cmd(8'h03, 8'h01, 16'(a), val, code, rb);
      chk(code, 8'h01, "R6 write success code");
      mv[a] = val;
   endtask

   task automatic do_bad(input logic [7:0] kind, input logic [7:0] cnt, input logic [15:0] addr,
                         input logic [7:0] ecode);
      logic [7:0] code, rb;
      run_cmd(kind, cnt, addr, 8'hA5, code, rb);
      chk(code, ecode, "R7 error code");
      chk(rb, 8'hA5, "R7 mailbox untouched on error");
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v, code, rb;
      for (int a = 0; a < VD; a++) mv[a] = 8'(a * SMUL + SADD);
      lv = 0; la = 0; ld = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int o = 0; o < 16; o++) begin
         peek(4'(o), v); chk(v, 8'h00, "R1 reset value");
      end

      // R2 pointer readback and window region gating
      wr(4'd2, 8'h04); wr(4'd3, 8'h80);
      peek(4'd2, v); chk(v, 8'h04, "R2 pointer low readback");
      peek(4'd3, v); chk(v, 8'h80, "R2 pointer high readback");
      wr(4'd4, 8'h3C);
      peek(4'd4, v); chk(v, 8'h3C, "R2 window write in region");
      wr(4'd3, 8'h7F); wr(4'd4, 8'hEE);
      peek(4'd4, v); chk(v, 8'h00, "R2 out-of-region read zero");
      wr(4'd3, 8'h80);
      peek(4'd4, v); chk(v, 8'h3C, "R2 out-of-region write ignored");
      wr(4'd2, 8'h06);
      peek(4'd7, v); chk(v, 8'h00, "R2 index beyond mailbox reads zero");

      // R3 non-go doorbell value starts nothing
      wr(4'd0, 8'h02);
      repeat (EXEC + 2) @(negedge clk);
      peek(4'd8, v); chk(v, 8'h00, "R3 other doorbell value ignored");
      peek(4'd0, v); chk(v, 8'h00, "R3 doorbell stays idle");

      // R11 R10 full read sweep of reset contents
      for (int a = 0; a < VD; a++) do_read(a);
      // R6 write sweep then read back
      for (int a = 0; a < VD; a++) do_write(a, 8'((a * 13 + 5) ^ 8'h5A));
      for (int a = VD - 1; a >= 0; a--) do_read(a);
      for (int a = 0; a < VD; a++) do_read(a);

      // R10 capture survives an intervening write
      do_read(10);
      do_write(11, 8'hC3);
      do_read(11);
      do_read(11);
      do_read(20);
      do_read(63);
      do_read(62);
      do_read(63);

      // R7 error codes and priority
      do_read(30);
      do_bad(8'h05, 8'h01, 16'd5,      8'h81);
      do_bad(8'h03, 8'h02, 16'd5,      8'h82);
      do_bad(8'h02, 8'h01, 16'd64,     8'h83);
      do_bad(8'h07, 8'h03, 16'h1234,   8'h81);
      do_bad(8'h02, 8'h00, 16'h8000,   8'h82);
      do_bad(8'h03, 8'h01, 16'hFFFF,   8'h83);
      do_read(31);
      do_read(5);

      // R8 status write-one-to-clear
      run_cmd(8'h02, 8'h01, 16'd40, 8'h00, code, rb);
      lv = 1; la = 41; ld = mv[41];
      chk(code, 8'h01, "R8 status before clear");
      wr(4'd1, 8'h00);
      peek(4'd1, v); chk(v, 8'h01, "R8 zero write keeps status");
      wr(4'd1, 8'h01);
      peek(4'd1, v); chk(v, 8'h00, "R8 one write clears status");

      // R9 interrupt write-one-to-clear
      wr(4'd8, 8'hFE);
      peek(4'd8, v); chk(v, 8'h01, "R9 bit0 kept by zero write");
      wr(4'd8, 8'h01);
      peek(4'd8, v); chk(v, 8'h00, "R9 bit0 cleared");
      do_read(41);

      for (int o = 9; o < 16; o++) begin
         peek(4'(o), v); chk(v, 8'h00, "R1 unused offset reads zero");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule